// File: doc/BRIEF.md
# Baud Clock Source Selector

This block makes the baud-rate enables for a serial controller running in UART or infrared modes. Each direction, transmit and receive, picks its own source through a 2-bit select field. One source is the bus clock, divided by a programmable divisor and then by a fixed prescale of 32. The other source is a pulse from an external timer. That pulse is resynchronised into the bus clock domain and then passed on either as it is or divided by 16.

Both outputs are single-cycle clock enables in the bus clock domain. No derived clocks are made, so the serial shifters that use these enables run on the same clock as the rest of the controller. A change to a direction's select field clears that direction's prescale count. This means the first enable after a switch never comes from a partly counted period.

Top module: `baud_clk_sel`

## Requirements
- R1: While reset is applied, and until the first full period has been counted after release, both `tx_en` and `rx_en` are low.
- R2: In a select field, bit 1 = 0 chooses the bus path (bit 0 is then ignored). Bit 1 = 1 chooses the timer path, where bit 0 = 0 means divide by 1 and bit 0 = 1 means divide by TMR_PRE (16 by default).
- R3: On the bus path, once running, successive enables are exactly `divisor * BUS_PRE` bus cycles apart (BUS_PRE is 32 by default).
- R4: A divisor of 0 gives the same enable spacing as a divisor of 1.
- R5: On the timer path with divide by 1, each rising edge of `tmr_in` gives exactly one enable. An input held high gives only one.
- R6: On the timer path with divide by TMR_PRE, one enable is produced for every TMR_PRE rising edges of `tmr_in`, counted from the last select change.
- R7: Transmit and receive take their sources independently. Each output follows only its own select field.
- R8: A change of a select field clears that direction's prescale count. The enable is low in the cycle after the change, and the next enable needs a full count of source events.
- R9: Each enable is high for one bus cycle at a time and is never high in two consecutive cycles.
- R10: An enable on the bus path follows only a divider tick, and an enable on the timer path follows only a synchronised timer edge. On the bus path, timer activity leaves the spacing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tmr_in | input | 1 | Timer output, asynchronous to clk |
| tx_sel | input | 2 | Transmit source select (encoding in R2) |
| rx_sel | input | 2 | Receive source select (encoding in R2) |
| divisor | input | DIV_W | Bus-path divisor, 0 treated as 1 |
| tx_en | output | 1 | Transmit baud enable |
| rx_en | output | 1 | Receive baud enable |

## Verification
The bench builds the block with a 4-bit divisor, a bus prescale of 8 and a timer prescale of 4. With these values the bench can sweep every divisor value, 0 included, and measure the exact spacing of the enables for each one in a few hundred cycles. The smaller timer prescale lets the bench count whole prescale groups, and a partial group before a select change, with only a handful of timer edges. The same small values put the start delay after a select change inside a narrow arithmetic window.

// File: rtl/baud_clk_pkg.sv
package baud_clk_pkg;
  typedef logic [1:0] src_sel_t;

  // bit 1: timer path, bit 0: timer prescale enable
  localparam int SEL_TMR_BIT = 1;
  localparam int SEL_PRE_BIT = 0;

  function automatic logic sel_is_timer(input src_sel_t s);
    return s[SEL_TMR_BIT];
  endfunction

  function automatic logic sel_uses_pre(input src_sel_t s);
    return s[SEL_PRE_BIT];
  endfunction
endpackage

// File: rtl/baud_sync_edge.sv
module baud_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_pulse = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/baud_div.sv
module baud_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, eff;
  logic             tick_q, tick_d;

  always_comb begin
    eff    = (divisor == '0) ? DIV_W'(1) : divisor;
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (cnt_q == '0) begin
      cnt_d  = eff - 1'b1;
      tick_d = 1'b1;
    end else begin
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/baud_chan.sv
module baud_chan
  import baud_clk_pkg::*;
#(
  parameter int BUS_PRE = 32,
  parameter int TMR_PRE = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  src_sel_t sel,
  input  logic     div_tick,
  input  logic     tmr_pulse,
  output logic     baud_en
);
  localparam int MAXP = (BUS_PRE > TMR_PRE) ? BUS_PRE : TMR_PRE;
  localparam int CW   = (MAXP > 2) ? $clog2(MAXP) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  src_sel_t      sel_q, sel_d;
  logic          en_q, en_d;

  always_comb begin
    cnt_d = cnt_q;
    en_d  = 1'b0;
    sel_d = sel;
    if (sel != sel_q) begin
      cnt_d = '0;
    end else if (!sel_is_timer(sel)) begin
      if (div_tick) begin
        if (cnt_q == CW'(BUS_PRE - 1)) begin
          cnt_d = '0;
          en_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else if (sel_uses_pre(sel)) begin
      if (tmr_pulse) begin
        if (cnt_q == CW'(TMR_PRE - 1)) begin
          cnt_d = '0;
          en_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else begin
      en_d = tmr_pulse;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sel_q <= sel_d;
      en_q  <= en_d;
    end
  end

  assign baud_en = en_q;
endmodule

// File: rtl/baud_clk_sel.sv
module baud_clk_sel
  import baud_clk_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int BUS_PRE     = 32,
  parameter int TMR_PRE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_in,
  input  logic [1:0]       tx_sel,
  input  logic [1:0]       rx_sel,
  input  logic [DIV_W-1:0] divisor,
  output logic             tx_en,
  output logic             rx_en
);
  localparam int NCH = 2;

  logic [1:0] rst_sh;
  logic       rst_int_n;
  logic       div_tick;
  logic       tmr_pulse;
  src_sel_t   sel_arr [NCH];
  logic [NCH-1:0] en_arr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= '0;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_int_n = rst_sh[1];

  baud_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .async_in   (tmr_in),
    .rise_pulse (tmr_pulse)
  );

  baud_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .divisor (divisor),
    .tick    (div_tick)
  );

  assign sel_arr[0] = tx_sel;
  assign sel_arr[1] = rx_sel;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    baud_chan #(.BUS_PRE(BUS_PRE), .TMR_PRE(TMR_PRE)) u_chan (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .sel       (sel_arr[i]),
      .div_tick  (div_tick),
      .tmr_pulse (tmr_pulse),
      .baud_en   (en_arr[i])
    );
  end

  assign tx_en = en_arr[0];
  assign rx_en = en_arr[1];
endmodule

// File: rtl/baud_clk_sel_chk.sv
module baud_clk_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] tx_sel,
  input logic [1:0] rx_sel,
  input logic       tx_en,
  input logic       rx_en,
  input logic       div_tick,
  input logic       tmr_pulse
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !tx_en && !rx_en);

  // R9
  tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_en |=> !tx_en);
  // R9
  rx_single_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_en |=> !rx_en);

  // R8
  tx_selchg_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(tx_sel) |=> !tx_en);
  // R8
  rx_selchg_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(rx_sel) |=> !rx_en);

  // R10
  tx_bus_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !$past(tx_sel[1])) |-> $past(div_tick));
  // R10
  tx_tmr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $past(tx_sel[1])) |-> $past(tmr_pulse));
  // R7
  rx_bus_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !$past(rx_sel[1])) |-> $past(div_tick));
  // R7
  rx_tmr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && $past(rx_sel[1])) |-> $past(tmr_pulse));

  // R5
  tmr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n) tmr_pulse |=> !tmr_pulse);
endmodule

bind baud_clk_sel baud_clk_sel_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_sel    (tx_sel),
  .rx_sel    (rx_sel),
  .tx_en     (tx_en),
  .rx_en     (rx_en),
  .div_tick  (div_tick),
  .tmr_pulse (tmr_pulse)
);

// File: tb/baud_clk_sel_test.sv
`timescale 1ns/1ps
module baud_clk_sel_test;
  localparam int DW = 4;
  localparam int BP = 8;
  localparam int TP = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tmr_in;
  logic [1:0]    tx_sel, rx_sel;
  logic [DW-1:0] divisor;
  logic          tx_en, rx_en;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int tx_cnt = 0, rx_cnt = 0;
  int tx_last = 0, tx_prev = 0;
  int dbl = 0;
  logic tx_was = 1'b0, rx_was = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  baud_clk_sel #(.DIV_W(DW), .BUS_PRE(BP), .TMR_PRE(TP)) uut (
    .clk(clk), .rst_n(rst_n), .tmr_in(tmr_in), .tx_sel(tx_sel), .rx_sel(rx_sel),
    .divisor(divisor), .tx_en(tx_en), .rx_en(rx_en)
  );

  always @(posedge clk) begin
    #2;
    cyc++;
    if (tx_en) begin tx_cnt++; tx_prev = tx_last; tx_last = cyc; end
    if (rx_en) rx_cnt++;
    if ((tx_en && tx_was) || (rx_en && rx_was)) dbl++;
    tx_was = tx_en;
    rx_was = rx_en;
  end

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic check_rng(input string req, input int got, input int lo, input int hi);
    total++;
    if (got < lo || got > hi) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d..%0d", req, got, lo, hi);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tmr_edges(input int n);
    for (int k = 0; k < n; k++) begin
      tmr_in = 1'b1; idle(3);
      tmr_in = 1'b0; idle(3);
    end
  endtask

  task automatic wait_tx(input int n);
    int target;
    target = tx_cnt + n;
    while (tx_cnt < target) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0, c1, r0, tc;
    rst_n = 1'b0; tmr_in = 1'b0; tx_sel = 2'b00; rx_sel = 2'b00; divisor = '1;
    idle(5);
    // R1: quiet in reset and right after release
    check("R1 tx in reset", int'(tx_en), 0);
    check("R1 rx in reset", int'(rx_en), 0);
    rst_n = 1'b1;
    idle(20);
    check("R1 no early tx", tx_cnt, 0);
    check("R1 no early rx", rx_cnt, 0);

    // R3/R4/R2: sweep every divisor on the bus path (bit0 set: ignored on bus path)
    for (int d = 0; d < (1 << DW); d++) begin
      int eff;
      eff = (d == 0) ? 1 : d;
      divisor = DW'(d);
      tx_sel = 2'b10; idle(2);
      tx_sel = (d % 2 == 0) ? 2'b00 : 2'b01;
      wait_tx(2);
      wait_tx(1);
      check(d == 0 ? "R4 divisor zero spacing" : "R3 bus spacing", tx_last - tx_prev, eff * BP);
      wait_tx(1);
      check("R2 bus path bit0 ignored", tx_last - tx_prev, eff * BP);
    end

    // R10: timer activity does not disturb the bus path
    divisor = DW'(2);
    wait_tx(2);
    fork tmr_edges(20); join_none
    wait_tx(2);
    check("R10 bus spacing with timer active", tx_last - tx_prev, 2 * BP);
    wait fork;
    idle(10);

    // R5: timer divide by 1
    tx_sel = 2'b10; idle(5);
    c0 = tx_cnt;
    tmr_edges(7); idle(8);
    check("R5 one enable per edge", tx_cnt - c0, 7);
    c0 = tx_cnt;
    tmr_in = 1'b1; idle(20); tmr_in = 1'b0; idle(8);
    check("R5 held high gives one", tx_cnt - c0, 1);

    // R6: timer divide by TP
    tx_sel = 2'b11; idle(5);
    c0 = tx_cnt;
    tmr_edges(3 * TP + 2); idle(8);
    check("R6 prescaled timer count", tx_cnt - c0, 3);

    // R8: partial count discarded on select change
    tx_sel = 2'b10; idle(3);
    tx_sel = 2'b11; idle(3);
    c0 = tx_cnt;
    tmr_edges(TP - 1); idle(8);
    check("R8 partial group gives none", tx_cnt - c0, 0);
    tx_sel = 2'b10; idle(3);
    tx_sel = 2'b11; idle(3);
    tmr_edges(TP - 1); idle(8);
    check("R8 restarted count no early enable", tx_cnt - c0, 0);
    tmr_edges(1); idle(8);
    check("R8 full group after restart", tx_cnt - c0, 1);

    // R8: bus path restart delay after select change (divisor 3)
    divisor = DW'(3);
    tx_sel = 2'b00; idle(2);
    wait_tx(2);
    idle(12);
    tx_sel = 2'b10; idle(2);
    c0 = tx_cnt;
    tx_sel = 2'b00;
    tc = cyc;
    wait_tx(1);
    check_rng("R8 full bus period after change", tx_last - tc, (BP - 1) * 3 + 2, BP * 3 + 1);

    // R7: independent sources
    divisor = DW'(1);
    tx_sel = 2'b00; rx_sel = 2'b10; idle(5);
    r0 = rx_cnt;
    wait_tx(1);
    tmr_edges(10); idle(8);
    check("R7 rx timer count with tx on bus", rx_cnt - r0, 10);
    check("R7 tx bus spacing with rx on timer", tx_last - tx_prev, BP);
    tx_sel = 2'b10; rx_sel = 2'b11; idle(5);
    c0 = tx_cnt; r0 = rx_cnt;
    tmr_edges(2 * TP); idle(8);
    check("R7 tx timer x1", tx_cnt - c0, 2 * TP);
    check("R7 rx timer prescaled", rx_cnt - r0, 2);
    c1 = tx_cnt;

    // R9: never two consecutive enables
    check("R9 single-cycle enables", dbl, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule